// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a host a window onto 256 byte-wide configuration registers through just two bus addresses. A byte written to the lower address picks a register; a byte written to the upper address is stored into the picked register. Reads from either address return the picked register. Each register has its own write rule. Most of the space is read-only. A handful of registers take any value. Two registers accept only one fixed code and drop every other value.

The whole port answers only while an external enable input is high. The enable normally comes from a bit in a bridge configuration byte. When the enable is low, the port ignores all bus traffic and drives all-ones on the read bus. The bus is a simple synchronous one. Reads are combinational from the register array. A write lands on the clock edge at which its strobe is sampled.

Top module: `cfgport_top`

## Requirements
- R1: After synchronous reset the index is 0x00. Registers 0xE0, 0xE2, 0xE3, 0xE6, 0xE7 and 0xE8 hold 0x3C, 0x03, 0xFC, 0xDE, 0xFE and 0xBE. Every other register holds 0x00.
- R2: With the port enabled, a write strobe at address BASE_ADDR (default 0x03F0) loads the write byte into the index. A read strobe at BASE_ADDR or at BASE_ADDR+1 returns the register the index selects.
- R3: While port_en is low, rd_data is 0xFF.
- R4: While port_en is low, write strobes change neither the index nor any register.
- R5: A data write (write strobe at BASE_ADDR+1) is dropped when the index lies in 0x00–0xDF, 0xE9–0xED, 0xF9–0xFB or 0xFD–0xFF.
- R6: A data write is dropped when the index is 0xE4, 0xE5, 0xF3, 0xF5 or 0xF7.
- R7: At index 0xE7 a data write is kept only when the byte is 0xFE. At index 0xE8 it is kept only when the byte is 0xBE.
- R8: At indices 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC a data write stores any byte. The new value is readable from the next cycle.
- R9: Accesses at any address other than BASE_ADDR and BASE_ADDR+1 have no effect. rd_data is 0xFF unless a read strobe hits one of the two port addresses while the port is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port enable; low makes the port inert |
| bus_addr | input | ADDR_W | Bus address |
| wr_stb | input | 1 | Write strobe, sampled on the rising clock edge |
| rd_stb | input | 1 | Read strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, combinational |

## Verification
A read result belongs to the same cycle as its strobe. The bench therefore compares rd_data halfway through the low clock phase, after the inputs have settled from the falling edge. An index or data write changes state at the following rising edge. The reference model applies each write only after that edge, so the first read that can show a write is the one in the next cycle. The disabled-port and stray-address checks read back through the normal port in the cycles after the stimulus. This shows that the index and the registers stayed untouched.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int IDX_W = 8;
    localparam int NREG  = 1 << IDX_W;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        logic idx_we;
        logic dat_req;
        logic rd_hit;
    } bus_op_t;

    function automatic logic idx_locked(input byte_t i);
        logic in_range;
        logic single;
        in_range = (i <= 8'hDF) ||
                   (i >= 8'hE9 && i <= 8'hED) ||
                   (i >= 8'hF9 && i <= 8'hFB) ||
                   (i >= 8'hFD);
        single   = (i == 8'hE4) || (i == 8'hE5) || (i == 8'hF3) ||
                   (i == 8'hF5) || (i == 8'hF7);
        return in_range || single;
    endfunction

    function automatic logic write_ok(input byte_t i, input byte_t v);
        if (idx_locked(i))       return 1'b0;
        else if (i == 8'hE7)     return v == 8'hFE;
        else if (i == 8'hE8)     return v == 8'hBE;
        else                     return 1'b1;
    endfunction

    function automatic byte_t reset_value(input int unsigned i);
        case (i)
            32'hE0:  return 8'h3C;
            32'hE2:  return 8'h03;
            32'hE3:  return 8'hFC;
            32'hE6:  return 8'hDE;
            32'hE7:  return 8'hFE;
            32'hE8:  return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
    import cfgport_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
    input  logic              port_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_stb,
    input  logic              rd_stb,
    output bus_op_t           op
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

    logic at_idx;
    logic at_dat;

    always_comb begin
        at_idx    = (bus_addr == BASE_ADDR);
        at_dat    = (bus_addr == DATA_ADDR);
        op.idx_we  = port_en && wr_stb && at_idx;
        op.dat_req = port_en && wr_stb && at_dat;
        op.rd_hit  = port_en && rd_stb && (at_idx || at_dat);
    end
endmodule

// File: rtl/cfgport_filter.sv
module cfgport_filter
    import cfgport_pkg::*;
(
    input  byte_t sel_idx,
    input  byte_t wr_data,
    input  logic  dat_req,
    output logic  cell_we
);
    always_comb cell_we = dat_req && write_ok(sel_idx, wr_data);
endmodule

// File: rtl/cfgport_store.sv
module cfgport_store
    import cfgport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  idx_we,
    input  logic  cell_we,
    input  byte_t wr_data,
    output byte_t sel_idx,
    output byte_t sel_val
);
    byte_t cells [NREG];

    always_ff @(posedge clk) begin
        if (rst)         sel_idx <= '0;
        else if (idx_we) sel_idx <= wr_data;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= reset_value(g);
            else if (cell_we && (sel_idx == byte_t'(g)))
                cells[g] <= wr_data;
        end
    end

    always_comb sel_val = cells[sel_idx];
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);
    bus_op_t op;
    byte_t   sel_idx;
    byte_t   sel_val;
    logic    cell_we;

    cfgport_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .port_en (port_en),
        .bus_addr(bus_addr),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .op      (op)
    );

    cfgport_filter u_flt (
        .sel_idx(sel_idx),
        .wr_data(wr_data),
        .dat_req(op.dat_req),
        .cell_we(cell_we)
    );

    cfgport_store u_sto (
        .clk    (clk),
        .rst    (rst),
        .idx_we (op.idx_we),
        .cell_we(cell_we),
        .wr_data(wr_data),
        .sel_idx(sel_idx),
        .sel_val(sel_val)
    );

    always_comb rd_data = op.rd_hit ? sel_val : 8'hFF;
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
    input logic              clk,
    input logic              rst,
    input logic              port_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wr_stb,
    input logic [7:0]        wr_data,
    input logic [7:0]        rd_data,
    input logic [7:0]        sel_idx,
    input logic [7:0]        sel_val
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

    logic dat_wr;
    logic range_lock;
    logic single_lock;
    logic free_idx;

    always_comb begin
        dat_wr      = port_en && wr_stb && (bus_addr == DATA_ADDR);
        range_lock  = (sel_idx < 8'hE0) || (sel_idx > 8'hFC) ||
                      (sel_idx inside {[8'hE9:8'hED], [8'hF9:8'hFB]});
        single_lock = sel_idx inside {8'hE4, 8'hE5, 8'hF3, 8'hF5, 8'hF7};
        free_idx    = sel_idx inside {[8'hE0:8'hE3], 8'hE6, [8'hEE:8'hF2],
                                      8'hF4, 8'hF6, 8'hF8, 8'hFC};
    end

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (rst)
        port_en && wr_stb && (bus_addr == BASE_ADDR) |=> sel_idx == $past(wr_data));

    // R3
    off_read_chk: assert property (@(posedge clk) disable iff (rst)
        !port_en |-> rd_data == 8'hFF);

    // R4
    off_index_chk: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> $stable(sel_idx));

    // R5
    range_drop_chk: assert property (@(posedge clk) disable iff (rst)
        dat_wr && range_lock |=> $stable(sel_val));

    // R6
    single_drop_chk: assert property (@(posedge clk) disable iff (rst)
        dat_wr && single_lock |=> $stable(sel_val));

    // R7
    fixed_code_chk: assert property (@(posedge clk) disable iff (rst)
        dat_wr && (((sel_idx == 8'hE7) && (wr_data != 8'hFE)) ||
                   ((sel_idx == 8'hE8) && (wr_data != 8'hBE))) |=> $stable(sel_val));

    // R8
    free_store_chk: assert property (@(posedge clk) disable iff (rst)
        dat_wr && free_idx |=> sel_val == $past(wr_data));
endmodule

bind cfgport_top cfgport_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .port_en (port_en),
    .bus_addr(bus_addr),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .sel_idx (sel_idx),
    .sel_val (sel_val)
);

// File: tb/cfgport_top_tb.sv
module cfgport_top_tb_top;
    localparam int          AW   = 16;
    localparam logic [15:0] BASE = 16'h03F0;
    localparam logic [15:0] DATA = 16'h03F1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_en = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        wr_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    int model_mem [256];
    int model_idx;

    always #10 clk = ~clk;

    cfgport_top #(.ADDR_W(AW), .BASE_ADDR(BASE)) dut_i (
        .clk(clk), .rst(rst), .port_en(port_en), .bus_addr(bus_addr),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic bit accepts(int i, int v);
        case (i)
            'hE0, 'hE1, 'hE2, 'hE3, 'hE6, 'hEE, 'hEF, 'hF0,
            'hF1, 'hF2, 'hF4, 'hF6, 'hF8, 'hFC: return 1'b1;
            'hE7: return v == 'hFE;
            'hE8: return v == 'hBE;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(int i);
        if (i == 'hE7 || i == 'hE8) return "R7";
        if (i == 'hE4 || i == 'hE5 || i == 'hF3 || i == 'hF5 || i == 'hF7) return "R6";
        if (accepts(i, 0)) return "R8";
        return "R5";
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 256; k++) model_mem[k] = 0;
        model_mem['hE0] = 'h3C; model_mem['hE2] = 'h03; model_mem['hE3] = 'hFC;
        model_mem['hE6] = 'hDE; model_mem['hE7] = 'hFE; model_mem['hE8] = 'hBE;
        model_idx = 0;
    endtask

    // one bus cycle: drive at falling edge, compare mid-phase, update model after rising edge
    task automatic step(input logic [15:0] a, input bit w, input bit r,
                        input int d, input bit en, input string tag);
        int exp;
        @(negedge clk);
        bus_addr = a; wr_stb = w; rd_stb = r; wr_data = 8'(d); port_en = en;
        #5;
        exp = (en && r && (a == BASE || a == DATA)) ? model_mem[model_idx] : 'hFF;
        checks++;
        if (rd_data !== 8'(exp)) begin
            errors++;
            $display("FAIL %s: addr=%h idx=%h rd_data=%h expected=%h",
                     tag, a, model_idx, rd_data, exp[7:0]);
        end
        @(posedge clk);
        if (en && w && a == BASE) model_idx = d & 'hFF;
        else if (en && w && a == DATA && accepts(model_idx, d & 'hFF))
            model_mem[model_idx] = d & 'hFF;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_stb = 1'b0; rd_stb = 1'b0; port_en = 1'b0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        step(DATA, 0, 1, 0, 0, "R3");

        // R1: full reset image, read through both addresses (R2)
        for (int i = 0; i < 256; i++) begin
            step(BASE, 1, 0, i, 1, "R2");
            step(DATA, 0, 1, 0, 1, "R1");
            step(BASE, 0, 1, 0, 1, "R2");
        end

        // R3/R4: disabled port is inert
        step(BASE, 1, 1, 'hE0, 0, "R4");
        step(DATA, 1, 1, 'h11, 0, "R4");
        step(DATA, 0, 1, 0, 0, "R3");
        step(DATA, 0, 1, 0, 1, "R4");
        step(BASE, 1, 0, 'hE0, 1, "R2");
        step(DATA, 1, 0, 'h22, 0, "R4");
        step(DATA, 0, 1, 0, 1, "R4");

        // R5-R8: write every index, read back
        for (int i = 0; i < 256; i++) begin
            step(BASE, 1, 0, i, 1, "R2");
            step(DATA, 1, 0, i ^ 'hA5, 1, tag_of(i));
            step(DATA, 0, 1, 0, 1, tag_of(i));
        end

        // R7: fixed-code registers
        step(BASE, 1, 0, 'hE7, 1, "R7");
        step(DATA, 1, 0, 'h00, 1, "R7");
        step(DATA, 0, 1, 0, 1, "R7");
        step(DATA, 1, 0, 'hFE, 1, "R7");
        step(DATA, 0, 1, 0, 1, "R7");
        step(BASE, 1, 0, 'hE8, 1, "R7");
        step(DATA, 1, 0, 'hFE, 1, "R7");
        step(DATA, 0, 1, 0, 1, "R7");
        step(DATA, 1, 0, 'hBE, 1, "R7");
        step(DATA, 0, 1, 0, 1, "R7");

        // R8: free registers take extreme values
        step(BASE, 1, 0, 'hE0, 1, "R8");
        step(DATA, 1, 0, 'h00, 1, "R8");
        step(DATA, 0, 1, 0, 1, "R8");
        step(DATA, 1, 0, 'hFF, 1, "R8");
        step(DATA, 0, 1, 0, 1, "R8");
        step(BASE, 1, 0, 'hFC, 1, "R8");
        step(DATA, 1, 0, 'h77, 1, "R8");
        step(BASE, 0, 1, 0, 1, "R8");

        // R9: stray addresses and strobe-less reads
        step(BASE + 16'd2, 1, 1, 'hE0, 1, "R9");
        step(BASE - 16'd1, 1, 1, 'h33, 1, "R9");
        step(DATA, 0, 0, 0, 1, "R9");
        step(DATA, 0, 1, 0, 1, "R9");

        // R1: reset in mid-run restores defaults
        do_reset();
        step(DATA, 0, 1, 0, 1, "R1");
        for (int i = 'hE0; i <= 'hE8; i++) begin
            step(BASE, 1, 0, i, 1, "R2");
            step(DATA, 0, 1, 0, 1, "R1");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule